// File: doc/BRIEF.md
# PHY Register Handshake Access Master

This block gives a simple command port access to 16-bit registers inside a PHY that are not on any memory map. The PHY exposes one control word, which this block drives, and one status word, which this block samples. Every transfer across that pair is a four-phase request/acknowledge exchange. The block raises a request bit, waits for the acknowledge to rise, drops the request and then waits for the acknowledge to fall.

An operation is built from a chain of these exchanges. First an address capture, then a data capture if the operation writes, then a write strobe or a read strobe. Every acknowledge wait samples the acknowledge once per programmable interval and gives up after a bounded number of samples. When a wait gives up, the whole operation ends with an error. A read-modify-write command chains a full read and a full write. It clears the masked bits of the value read, ORs in the supplied value, and writes the result back.

Top module: `phy_hs_master`

## Requirements
- R1: After reset, the control word is all zeros, `done` and `err` are low, `rdData` is zero and `cmdReady` is high.
- R2: Control word bits: payload in [15:0], capture-address at bit 16, capture-data at bit 17, write strobe at bit 18, read strobe at bit 19. At most one of bits 19:16 is ever high. Status word bits: acknowledge at bit 16, read data in [15:0].
- R3: The address exchange drives the address with no request bit, then the address with capture-address. After the acknowledge rises it drives the address alone, then waits for the acknowledge to fall.
- R4: A write (`cmdOp` 01) runs the address exchange, then the same pattern with capture-data on the data word, then the write strobe alone. After the acknowledge rises it drives the data word, waits for the acknowledge to fall, and finally drives the control word to zero.
- R5: A read (`cmdOp` 00) runs the address exchange, then drives the read strobe alone. After the acknowledge rises it latches status[15:0] into `rdData`, drives zero and waits for the acknowledge to fall.
- R6: A read-modify-write (`cmdOp` 10) performs R5, then performs R4 with data `(read & ~cmdMask) | cmdWdata`. `rdData` reports the value that was read.
- R7: In each wait, the acknowledge is sampled once every WAIT_CYCLES clocks, at most MAX_POLLS times. An acknowledge that is seen on the last sample still lets the operation continue.
- R8: If the last sample in a wait does not match, the operation aborts. The control word goes to zero, and `done` and `err` rise together. With no acknowledge at all, `done` follows the accepting edge by 1 + MAX_POLLS*WAIT_CYCLES clocks.
- R9: `done` is a one-cycle pulse. `err` is low on success and is high only together with `done`.
- R10: A command is taken only while `cmdReady` is high (idle). A `cmdValid` while busy has no effect on the control word sequence or the results. `cmdOp` 11 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdOp | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| cmdAddr | input | 16 | PHY register address |
| cmdWdata | input | 16 | Write data, or OR value for read-modify-write |
| cmdMask | input | 16 | Bits cleared in read-modify-write |
| cmdReady | output | 1 | High while idle |
| rdData | output | 16 | Last value read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| phyCtrl | output | 20 | Control word to the PHY |
| phyStat | input | 17 | Status word from the PHY |

## Verification
The control word changes after a fixed number of clocks from each acknowledge transition. The bench therefore holds the expected sequence of distinct control word values in a queue, and checks every change on the falling edge that follows the register update. `done` and `err` are checked on the falling edge after the edge that retires the last wait. For a PHY that never acknowledges, the bench counts edges from the accepting edge and expects exactly 1 + MAX_POLLS*WAIT_CYCLES. The bench also sets the responder latency so that the acknowledge lands exactly on the last permitted sample in one run and one clock later in another. The `done` pulse width is confirmed one falling edge after it appears.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_RMW   = 2'b10;

  // request bit offsets above the payload field
  localparam int REQ_CAP_ADDR = 0;
  localparam int REQ_CAP_DATA = 1;
  localparam int REQ_WRITE    = 2;
  localparam int REQ_READ     = 3;
  localparam int REQ_BITS     = 4;

  typedef enum logic [2:0] {
    SEL_KEEP,
    SEL_ADDR,
    SEL_ADDR_CAP,
    SEL_DATA,
    SEL_DATA_CAP,
    SEL_WR,
    SEL_RD,
    SEL_ZERO
  } ctrlSel_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_ASSERT,
    S_WAITH,
    S_RELEASE,
    S_WAITL
  } state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_DATA,
    PH_WSTB,
    PH_RSTB
  } phase_e;

  typedef struct packed {
    logic     loadCmd;
    ctrlSel_e sel;
    logic     latchRd;
    logic     mergeRmw;
    logic     finish;
    logic     abort;
  } dpCmd_t;

endpackage

// File: rtl/phy_hs_dp.sv
module phy_hs_dp
  import phy_hs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCmd_t                       dpCmd,
  input  logic [DATA_W-1:0]            cmdAddr,
  input  logic [DATA_W-1:0]            cmdWdata,
  input  logic [DATA_W-1:0]            cmdMask,
  input  logic [DATA_W:0]              phyStat,
  output logic [DATA_W+REQ_BITS-1:0]   phyCtrl,
  output logic [DATA_W-1:0]            rdData,
  output logic                         done,
  output logic                         err
);
  localparam int CTRL_W = DATA_W + REQ_BITS;

  logic [DATA_W-1:0] addrQ, wdataQ, maskQ, rdQ;
  logic [CTRL_W-1:0] ctrlQ, ctrlN;
  logic              doneQ, errQ;

  function automatic logic [CTRL_W-1:0] reqWord(input int bitIdx, input logic [DATA_W-1:0] pay);
    logic [REQ_BITS-1:0] r;
    r = '0;
    r[bitIdx] = 1'b1;
    return {r, pay};
  endfunction

  always_comb begin
    unique case (dpCmd.sel)
      SEL_KEEP:     ctrlN = ctrlQ;
      SEL_ADDR:     ctrlN = {{REQ_BITS{1'b0}}, (dpCmd.loadCmd ? cmdAddr : addrQ)};
      SEL_ADDR_CAP: ctrlN = reqWord(REQ_CAP_ADDR, addrQ);
      SEL_DATA:     ctrlN = {{REQ_BITS{1'b0}}, wdataQ};
      SEL_DATA_CAP: ctrlN = reqWord(REQ_CAP_DATA, wdataQ);
      SEL_WR:       ctrlN = reqWord(REQ_WRITE, '0);
      SEL_RD:       ctrlN = reqWord(REQ_READ, '0);
      default:      ctrlN = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      rdQ    <= '0;
      ctrlQ  <= '0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      ctrlQ <= ctrlN;
      if (dpCmd.loadCmd) begin
        addrQ  <= cmdAddr;
        wdataQ <= cmdWdata;
        maskQ  <= cmdMask;
      end else if (dpCmd.mergeRmw) begin
        wdataQ <= (rdQ & ~maskQ) | wdataQ;
      end
      if (dpCmd.latchRd) rdQ <= phyStat[DATA_W-1:0];
      doneQ <= dpCmd.finish | dpCmd.abort;
      errQ  <= dpCmd.abort;
    end
  end

  assign phyCtrl = ctrlQ;
  assign rdData  = rdQ;
  assign done    = doneQ;
  assign err     = errQ;

  p_one_request_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlQ[CTRL_W-1:DATA_W]))
    else $error("more than one request bit high");

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> doneQ)
    else $error("err without done");

  p_zero_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (ctrlQ == '0))
    else $error("control word not zero at done");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ)
    else $error("done longer than one cycle");

endmodule

// File: rtl/phy_hs_ctrl.sv
module phy_hs_ctrl
  import phy_hs_pkg::*;
#(
  parameter int MAX_POLLS   = 10,
  parameter int WAIT_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       ackIn,
  output logic       cmdReady,
  output dpCmd_t     dpCmd
);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);

  state_e             state, stateN;
  phase_e             phase, phaseN;
  logic               doRead, doReadN, doWrite, doWriteN;
  logic [POLL_W-1:0]  pollCnt;
  logic [WAIT_W-1:0]  waitCnt;
  logic               inWait, sampleNow, ackOk, lastPoll, reload;

  assign inWait    = (state == S_WAITH) || (state == S_WAITL);
  assign sampleNow = inWait && (waitCnt == '0);
  assign ackOk     = (state == S_WAITH) ? ackIn : !ackIn;
  assign lastPoll  = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign reload    = (state == S_ASSERT) || (state == S_RELEASE);
  assign cmdReady  = (state == S_IDLE);

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    doReadN  = doRead;
    doWriteN = doWrite;
    dpCmd    = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          dpCmd.loadCmd = 1'b1;
          dpCmd.sel     = SEL_ADDR;
          phaseN        = PH_ADDR;
          doReadN       = (cmdOp != OP_WRITE);
          doWriteN      = (cmdOp == OP_WRITE) || (cmdOp == OP_RMW);
          stateN        = S_ASSERT;
        end
      end
      S_SETUP: begin
        dpCmd.sel = (phase == PH_DATA) ? SEL_DATA : SEL_ADDR;
        stateN    = S_ASSERT;
      end
      S_ASSERT: begin
        unique case (phase)
          PH_ADDR: dpCmd.sel = SEL_ADDR_CAP;
          PH_DATA: dpCmd.sel = SEL_DATA_CAP;
          PH_WSTB: dpCmd.sel = SEL_WR;
          default: dpCmd.sel = SEL_RD;
        endcase
        stateN = S_WAITH;
      end
      S_RELEASE: begin
        unique case (phase)
          PH_ADDR: dpCmd.sel = SEL_ADDR;
          PH_RSTB: begin
            dpCmd.sel     = SEL_ZERO;
            dpCmd.latchRd = 1'b1;
          end
          default: dpCmd.sel = SEL_DATA;
        endcase
        stateN = S_WAITL;
      end
      S_WAITH, S_WAITL: begin
        if (sampleNow) begin
          if (ackOk) begin
            if (state == S_WAITH) begin
              stateN = S_RELEASE;
            end else begin
              unique case (phase)
                PH_ADDR: begin
                  phaseN = doRead ? PH_RSTB : PH_DATA;
                  stateN = doRead ? S_ASSERT : S_SETUP;
                end
                PH_DATA: begin
                  phaseN = PH_WSTB;
                  stateN = S_ASSERT;
                end
                PH_RSTB: begin
                  if (doWrite) begin
                    dpCmd.mergeRmw = 1'b1;
                    doReadN        = 1'b0;
                    phaseN         = PH_ADDR;
                    stateN         = S_SETUP;
                  end else begin
                    dpCmd.sel    = SEL_ZERO;
                    dpCmd.finish = 1'b1;
                    stateN       = S_IDLE;
                  end
                end
                default: begin
                  dpCmd.sel    = SEL_ZERO;
                  dpCmd.finish = 1'b1;
                  stateN       = S_IDLE;
                end
              endcase
            end
          end else if (lastPoll) begin
            dpCmd.sel   = SEL_ZERO;
            dpCmd.abort = 1'b1;
            stateN      = S_IDLE;
          end
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_ADDR;
      doRead  <= 1'b0;
      doWrite <= 1'b0;
      pollCnt <= '0;
      waitCnt <= '0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      doRead  <= doReadN;
      doWrite <= doWriteN;
      if (reload) begin
        pollCnt <= '0;
        waitCnt <= WAIT_W'(WAIT_CYCLES - 1);
      end else if (inWait) begin
        if (waitCnt != '0) begin
          waitCnt <= waitCnt - 1'b1;
        end else if (!lastPoll) begin
          pollCnt <= pollCnt + 1'b1;
          waitCnt <= WAIT_W'(WAIT_CYCLES - 1);
        end
      end
    end
  end

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    inWait |-> (pollCnt < POLL_W'(MAX_POLLS)))
    else $error("poll count beyond limit");

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> $stable(doWrite))
    else $error("operation changed while busy");

  p_wait_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inWait && !sampleNow) |=> (state == $past(state)))
    else $error("wait left between samples");

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int MAX_POLLS   = 10,
  parameter int WAIT_CYCLES = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [1:0]                 cmdOp,
  input  logic [DATA_W-1:0]          cmdAddr,
  input  logic [DATA_W-1:0]          cmdWdata,
  input  logic [DATA_W-1:0]          cmdMask,
  output logic                       cmdReady,
  output logic [DATA_W-1:0]          rdData,
  output logic                       done,
  output logic                       err,
  output logic [DATA_W+REQ_BITS-1:0] phyCtrl,
  input  logic [DATA_W:0]            phyStat
);
  dpCmd_t dpCmd;

  phy_hs_ctrl #(
    .MAX_POLLS  (MAX_POLLS),
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .ackIn   (phyStat[DATA_W]),
    .cmdReady(cmdReady),
    .dpCmd   (dpCmd)
  );

  phy_hs_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCmd   (dpCmd),
    .cmdAddr (cmdAddr),
    .cmdWdata(cmdWdata),
    .cmdMask (cmdMask),
    .phyStat (phyStat),
    .phyCtrl (phyCtrl),
    .rdData  (rdData),
    .done    (done),
    .err     (err)
  );

endmodule

// File: tb/phy_hs_master_tb.sv
module phy_hs_master_tb;
  localparam int MAXP = 10;
  localparam int WAITC = 2;
  localparam logic [19:0] CA = 20'h10000;
  localparam logic [19:0] CD = 20'h20000;
  localparam logic [19:0] WRS = 20'h40000;
  localparam logic [19:0] RDS = 20'h80000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [15:0] cmdAddr = '0, cmdWdata = '0, cmdMask = '0;
  logic        cmdReady, done, err;
  logic [15:0] rdData;
  logic [19:0] phyCtrl;
  logic [16:0] phyStat;

  always #2.5 clk = ~clk;

  phy_hs_master #(.DATA_W(16), .MAX_POLLS(MAXP), .WAIT_CYCLES(WAITC)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdMask(cmdMask),
    .cmdReady(cmdReady), .rdData(rdData), .done(done), .err(err),
    .phyCtrl(phyCtrl), .phyStat(phyStat)
  );

  // behavioural PHY responder
  int          rspMode = 0;  // 0 normal, 1 never acks, 2 ack never falls
  int          rspLat = 1;
  int          rspCnt = 0;
  logic        rspAck = 1'b0;
  logic [15:0] rspAddr = '0, rspData = '0;
  logic [15:0] phyMem [256];
  logic [15:0] refMem [256];
  logic        tgt;

  assign phyStat = {rspAck, (phyCtrl[19] ? phyMem[rspAddr[7:0]] : 16'hDEAD)};

  always_comb begin
    if (rspMode == 1) tgt = 1'b0;
    else if (rspMode == 2 && rspAck) tgt = 1'b1;
    else tgt = |phyCtrl[19:16];
  end

  always @(posedge clk) begin
    if (tgt != rspAck) begin
      if (rspCnt + 1 >= rspLat) begin
        rspAck <= tgt;
        rspCnt <= 0;
        if (tgt) begin
          if (phyCtrl[16]) rspAddr <= phyCtrl[15:0];
          if (phyCtrl[17]) rspData <= phyCtrl[15:0];
          if (phyCtrl[18]) phyMem[rspAddr[7:0]] <= rspData;
        end
      end else rspCnt <= rspCnt + 1;
    end else rspCnt <= 0;
  end

  int nChecks = 0, nFail = 0;
  logic [19:0] expQ[$];
  logic [19:0] lastExp = '0, prevCtrl = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic pushExp(input logic [19:0] v);
    if (v != lastExp) begin
      expQ.push_back(v);
      lastExp = v;
    end
  endtask

  // every clock: each change of the control word must be the next expected value (R2 R3 R4 R5)
  always @(negedge clk) begin
    if (rstN && phyCtrl !== prevCtrl) begin
      if (expQ.size() == 0) chk(1'b0, "R2", "unexpected control change", {12'b0, phyCtrl}, 0);
      else begin
        logic [19:0] e;
        e = expQ.pop_front();
        chk(phyCtrl === e, "R3", "control word sequence", {12'b0, phyCtrl}, {12'b0, e});
      end
      prevCtrl = phyCtrl;
    end
  end

  task automatic runCmd(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] m, input int tmo, input bit intrude, input string req);
    logic [15:0] r, nd;
    bit isRead, isWrite;
    int lat;
    isRead  = (op != 2'b01);
    isWrite = (op == 2'b01) || (op == 2'b10);
    r = refMem[a[7:0]];
    nd = d;
    if (tmo == 1) begin
      pushExp({4'b0, a}); pushExp({4'b0, a} | CA); pushExp(0);
    end else if (tmo == 2) begin
      pushExp({4'b0, a}); pushExp({4'b0, a} | CA); pushExp({4'b0, a}); pushExp(0);
    end else begin
      if (isRead) begin
        pushExp({4'b0, a}); pushExp({4'b0, a} | CA); pushExp({4'b0, a});
        pushExp(RDS); pushExp(0);
      end
      if (isWrite) begin
        if (op == 2'b10) nd = (r & ~m) | d;
        pushExp({4'b0, a}); pushExp({4'b0, a} | CA); pushExp({4'b0, a});
        pushExp({4'b0, nd}); pushExp({4'b0, nd} | CD); pushExp({4'b0, nd});
        pushExp(WRS); pushExp({4'b0, nd}); pushExp(0);
        refMem[a[7:0]] = nd;
      end
    end
    chk(cmdReady === 1'b1, "R10", "ready before command", {31'b0, cmdReady}, 1);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdWdata = d; cmdMask = m;
    @(negedge clk);
    cmdValid = 1'b0; cmdAddr = 16'h0055; cmdOp = 2'b00;
    lat = 0;
    while (lat < 3000) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 3) begin
        chk(cmdReady === 1'b0, "R10", "ready low while busy", {31'b0, cmdReady}, 0);
        cmdValid = 1'b1;
      end else cmdValid = 1'b0;
      if (done) break;
    end
    cmdValid = 1'b0;
    chk(done === 1'b1, req, "done seen", {31'b0, done}, 1);
    chk(err === (tmo != 0), "R9", "err at done", {31'b0, err}, {31'b0, (tmo != 0)});
    if (tmo == 1) chk(lat == 1 + MAXP * WAITC, "R8", "timeout latency", lat, 1 + MAXP * WAITC);
    if (tmo == 0 && isRead) chk(rdData === r, req, "rdData", {16'b0, rdData}, {16'b0, r});
    @(negedge clk);
    chk(done === 1'b0, "R9", "done pulse width", {31'b0, done}, 0);
    chk(cmdReady === 1'b1, "R8", "back to idle", {31'b0, cmdReady}, 1);
    chk(expQ.size() == 0, req, "expected control sequence consumed", expQ.size(), 0);
    expQ.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      phyMem[i] = '0;
      refMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(phyCtrl === 20'h0, "R1", "control after reset", {12'b0, phyCtrl}, 0);
    chk(done === 1'b0 && err === 1'b0, "R1", "done/err after reset", {30'b0, done, err}, 0);
    chk(rdData === 16'h0, "R1", "rdData after reset", {16'b0, rdData}, 0);
    chk(cmdReady === 1'b1, "R1", "ready after reset", {31'b0, cmdReady}, 1);

    runCmd(2'b01, 16'h0012, 16'hBEEF, 16'h0, 0, 0, "R4");
    runCmd(2'b00, 16'h0012, 16'h0, 16'h0, 0, 0, "R5");
    runCmd(2'b01, 16'h0000, 16'h0000, 16'h0, 0, 0, "R4");
    runCmd(2'b00, 16'h0000, 16'h0, 16'h0, 0, 0, "R5");
    runCmd(2'b10, 16'h0012, 16'h0050, 16'h00F0, 0, 0, "R6");
    runCmd(2'b00, 16'h0012, 16'h0, 16'h0, 0, 0, "R6");
    runCmd(2'b11, 16'h0012, 16'h0, 16'h0, 0, 0, "R10");
    runCmd(2'b01, 16'h0033, 16'h1234, 16'h0, 0, 1, "R10");
    runCmd(2'b00, 16'h0055, 16'h0, 16'h0, 0, 0, "R10");

    // R7 acknowledge on the last permitted sample
    rspLat = 1 + MAXP * WAITC - 2;
    runCmd(2'b01, 16'h0044, 16'hA5A5, 16'h0, 0, 0, "R7");
    runCmd(2'b10, 16'h0044, 16'h0003, 16'hFF00, 0, 0, "R7");
    // one clock later is too late
    rspLat = 1 + MAXP * WAITC - 1;
    runCmd(2'b00, 16'h0044, 16'h0, 16'h0, 1, 0, "R7");
    repeat (60) @(negedge clk);
    rspLat = 1;

    // R8 PHY never acknowledges
    rspMode = 1;
    runCmd(2'b01, 16'h0021, 16'h7777, 16'h0, 1, 0, "R8");
    rspMode = 0;
    repeat (10) @(negedge clk);

    // R8 acknowledge never falls
    rspMode = 2;
    runCmd(2'b00, 16'h0022, 16'h0, 16'h0, 2, 0, "R8");
    rspMode = 0;
    repeat (10) @(negedge clk);

    runCmd(2'b00, 16'h0044, 16'h0, 16'h0, 0, 0, "R5");

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule